// File: doc/BRIEF.md
# Pipelined 5x5 Signed Matrix Multiplier

This block computes C = A x B for two square matrices of signed 8-bit elements and writes the 16-bit signed product elements into an external result memory. Both operand matrices are stored outside the block. They are read through synchronous memory ports: the block presents an address and a chip enable, and the data arrives on the next cycle. The A memory is organised so that one word holds a whole row of A. The B memory is organised so that one word holds a whole column of B. With that layout, each read cycle supplies every operand of one complete dot product.

The row and column loops are flattened into a single stream of 25 output positions, taken in row-major order. The pipeline starts one dot product every cycle. Each output goes through four stages: issue the addresses, receive the memory data, register the five multiplies, and register the sum from the adder tree, which then drives the write port. Every product element starts from zero, so no result depends on an earlier run. A start/done/idle/ready handshake frames each run.

Top module: `mat5_mul_pipe`

## Requirements
- R1: While reset is held and afterwards until a start arrives, idle is 1, done and ready are 0, and a_ce, b_ce and c_ce are 0.
- R2: A start sampled while idle causes 25 reads in consecutive cycles, the first in the cycle after start. Read n (n = 0..24) uses a_addr = n / 5 and b_addr = n mod 5, and a_ce and b_ce are asserted together.
- R3: Element k of a row word sits at bits [8k+7:8k] of a_rdata and is A[i][k]. Element k of a column word sits at bits [8k+7:8k] of b_rdata and is B[k][j]. All elements are two's complement.
- R4: Each of the 25 product elements is written exactly once, as C[i][j] = sum over k = 0..4 of A[i][k]*B[k][j], at c_addr = 5i + j, with c_ce and c_we high. The writes fall in consecutive cycles, each three cycles after its read cycle, so they occupy cycles 4 to 28 after start.
- R5: A sum outside the 16-bit signed range wraps modulo 2^16 without saturation. Five terms of (-128)*(-128) give 16384. Five terms of (-128)*127 give -15744.
- R6: done and ready are high together for exactly one cycle, 29 cycles after the start edge, which is the cycle after the last write. idle is 0 from cycle 1 through cycle 29 and returns to 1 afterwards if no new start arrives.
- R7: A start raised while a run is in progress (cycles 1 to 28) is ignored. It does not change the read or write sequence and causes no extra done.
- R8: A start sampled in the done cycle is accepted. The next run's first read falls in the following cycle, and its done comes 29 cycles after the previous done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a multiplication |
| done | output | 1 | One-cycle pulse after the last result write |
| idle | output | 1 | High while no run is active |
| ready | output | 1 | One-cycle pulse when a new start can be taken (coincides with done) |
| a_addr | output | 3 | Row index of A to read |
| a_ce | output | 1 | Read enable of the A memory |
| a_rdata | input | 40 | One row of A, five packed 8-bit elements |
| b_addr | output | 3 | Column index of B to read |
| b_ce | output | 1 | Read enable of the B memory |
| b_rdata | input | 40 | One column of B, five packed 8-bit elements |
| c_addr | output | 5 | Linear result address 5i + j |
| c_ce | output | 1 | Result memory enable |
| c_we | output | 1 | Result memory write enable |
| c_wdata | output | 16 | Product element C[i][j] |

## Verification
Timing is counted from the clock edge that samples start, which is cycle 0. Reads are due in cycles 1 to 25, writes in cycles 4 to 28, and the done/ready pulse in cycle 29; idle is expected back in cycle 30. The bench samples every output half a cycle after each edge and compares it against the cycle in which that output is due. A result memory model captures the writes, and its contents are compared against products that the bench computes itself, wrapped to 16 bits. The busy-start case checks the same cycle timing with extra start pulses in cycles 10 and 27, and the back-to-back case measures the distance from one done to the next.

// File: rtl/mm_pkg.sv
package mm_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_DRAIN = 2'd2,
      ST_DONE  = 2'd3
   } mm_state_e;
endpackage

// File: rtl/mm_ctrl.sv
module mm_ctrl
   import mm_pkg::*;
#(
   parameter int DIM = 5,
   parameter int IW  = $clog2(DIM)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          last_wr,
   output logic          issue,
   output logic [IW-1:0] row,
   output logic [IW-1:0] col,
   output logic          done,
   output logic          ready,
   output logic          idle
);
   localparam logic [IW-1:0] LAST_IDX = IW'(DIM - 1);

   mm_state_e st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_IDLE;
         row <= '0;
         col <= '0;
      end else begin
         unique case (st)
            ST_IDLE, ST_DONE: begin
               if (start) begin
                  st  <= ST_RUN;
                  row <= '0;
                  col <= '0;
               end else begin
                  st <= ST_IDLE;
               end
            end
            ST_RUN: begin
               if (col == LAST_IDX) begin
                  col <= '0;
                  if (row == LAST_IDX) st <= ST_DRAIN;
                  else                 row <= row + 1'b1;
               end else begin
                  col <= col + 1'b1;
               end
            end
            ST_DRAIN: begin
               if (last_wr) st <= ST_DONE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign issue = (st == ST_RUN);
   assign done  = (st == ST_DONE);
   assign ready = (st == ST_DONE);
   assign idle  = (st == ST_IDLE);

   // R7: while a run is being issued the controller cannot drop back to idle
   p_run_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RUN) |=> (st != ST_IDLE));
endmodule

// File: rtl/mm_dot.sv
module mm_dot #(
   parameter int DIM = 5,
   parameter int AW  = 8,
   parameter int PW  = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_vld,
   input  logic [DIM*AW-1:0]    a_row,
   input  logic [DIM*AW-1:0]    b_col,
   output logic                 out_vld,
   output logic signed [PW-1:0] out_sum
);
   localparam int NL = $clog2(DIM);
   localparam int P2 = 1 << NL;

   logic signed [2*AW-1:0] mul  [DIM];
   logic signed [PW-1:0]   p_q  [DIM];
   logic signed [PW-1:0]   tree [2*P2-1];
   logic                   p_vld;

   genvar k;
   generate
      for (k = 0; k < DIM; k++) begin : g_lane
         logic signed [AW-1:0] ea, eb;
         assign ea     = a_row[k*AW +: AW];
         assign eb     = b_col[k*AW +: AW];
         assign mul[k] = ea * eb;
         always_ff @(posedge clk) begin
            if (in_vld) p_q[k] <= PW'(mul[k]);
         end
      end
   endgenerate

   // balanced adder tree, heap-indexed, unused leaves tied to zero
   always_comb begin
      for (int n = 0; n < P2; n++) begin
         tree[P2-1+n] = (n < DIM) ? p_q[n] : '0;
      end
      for (int n = P2 - 2; n >= 0; n--) begin
         tree[n] = tree[2*n+1] + tree[2*n+2];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_vld   <= 1'b0;
         out_vld <= 1'b0;
      end else begin
         p_vld   <= in_vld;
         out_vld <= p_vld;
      end
   end

   always_ff @(posedge clk) begin
      if (p_vld) out_sum <= tree[0];
   end

   // R4: a sum leaves exactly two cycles after its operands arrived
   p_two_stage_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> $past(in_vld, 2));
endmodule

// File: rtl/mat5_mul_pipe.sv
module mat5_mul_pipe #(
   parameter int DIM = 5,
   parameter int AW  = 8,
   parameter int PW  = 16,
   parameter int IW  = $clog2(DIM),
   parameter int CW  = $clog2(DIM*DIM)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              done,
   output logic              idle,
   output logic              ready,
   output logic [IW-1:0]     a_addr,
   output logic              a_ce,
   input  logic [DIM*AW-1:0] a_rdata,
   output logic [IW-1:0]     b_addr,
   output logic              b_ce,
   input  logic [DIM*AW-1:0] b_rdata,
   output logic [CW-1:0]     c_addr,
   output logic              c_ce,
   output logic              c_we,
   output logic [PW-1:0]     c_wdata
);
   localparam logic [CW-1:0] LAST_POS = CW'(DIM*DIM - 1);

   generate
      if (DIM < 2)    begin : g_chk_dim   $error("DIM must be at least 2");            end
      if (PW < 2*AW)  begin : g_chk_width $error("PW must hold a full product");       end
      if (IW != $clog2(DIM))     begin : g_chk_iw $error("IW must equal clog2(DIM)");  end
      if (CW != $clog2(DIM*DIM)) begin : g_chk_cw $error("CW must match DIM*DIM");     end
   endgenerate

   logic          issue, last_wr;
   logic [IW-1:0] row, col;
   logic [CW-1:0] pos0, pos1, pos2, pos3;
   logic          rd_vld;
   logic          sum_vld;
   logic signed [PW-1:0] sum;

   mm_ctrl #(.DIM(DIM), .IW(IW)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .last_wr (last_wr),
      .issue   (issue),
      .row     (row),
      .col     (col),
      .done    (done),
      .ready   (ready),
      .idle    (idle)
   );

   assign a_addr = row;
   assign b_addr = col;
   assign a_ce   = issue;
   assign b_ce   = issue;
   assign pos0   = CW'(int'(row) * DIM + int'(col));

   // position and valid follow the data through the memory and the datapath
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_vld <= 1'b0;
      else        rd_vld <= issue;
   end

   always_ff @(posedge clk) begin
      pos1 <= pos0;
      pos2 <= pos1;
      pos3 <= pos2;
   end

   mm_dot #(.DIM(DIM), .AW(AW), .PW(PW)) u_dot (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_vld  (rd_vld),
      .a_row   (a_rdata),
      .b_col   (b_rdata),
      .out_vld (sum_vld),
      .out_sum (sum)
   );

   assign c_ce    = sum_vld;
   assign c_we    = sum_vld;
   assign c_addr  = pos3;
   assign c_wdata = sum;
   assign last_wr = sum_vld && (pos3 == LAST_POS);

   // R1: nothing touches memory while idle
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> (!a_ce && !b_ce && !c_ce));

   // R2: consecutive reads walk the positions in row-major order
   p_read_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (a_ce && $past(a_ce)) |->
         (int'(a_addr) * DIM + int'(b_addr) ==
          int'($past(a_addr)) * DIM + int'($past(b_addr)) + 1));

   // R7: a read burst only begins after a start that came while idle or done
   p_burst_needs_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(a_ce) |-> ($past(start) && $past(idle || ready)));

   // R4: writes come three cycles after their read and step through addresses
   p_write_lag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      c_ce |-> $past(a_ce, 3));
   p_write_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (c_ce && $past(c_ce)) |-> (c_addr == $past(c_addr) + 1'b1));

   // R6: done follows the last write and lasts a single cycle
   p_done_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(c_ce) && ($past(c_addr) == LAST_POS)));
   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: tb/sim_mat5_mul_pipe.sv
`timescale 1ns/1ps
module sim_mat5_mul_pipe;
   localparam int DIM = 5;
   localparam int AW  = 8;
   localparam int PW  = 16;
   localparam int IW  = 3;
   localparam int CW  = 5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic              done, idle, ready;
   logic [IW-1:0]     a_addr, b_addr;
   logic              a_ce, b_ce;
   logic [DIM*AW-1:0] a_rd, b_rd;
   logic [CW-1:0]     c_addr;
   logic              c_ce, c_we;
   logic [PW-1:0]     c_wdata;

   int errors = 0;
   int checks = 0;
   int wr_total = 0;

   logic signed [AW-1:0] ma [DIM][DIM];
   logic signed [AW-1:0] mb [DIM][DIM];
   logic [PW-1:0]        cmem [DIM*DIM];

   always #10 clk = ~clk;   // 50 MHz

   mat5_mul_pipe u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .done(done), .idle(idle),
      .ready(ready), .a_addr(a_addr), .a_ce(a_ce), .a_rdata(a_rd),
      .b_addr(b_addr), .b_ce(b_ce), .b_rdata(b_rd), .c_addr(c_addr),
      .c_ce(c_ce), .c_we(c_we), .c_wdata(c_wdata)
   );

   function automatic logic [DIM*AW-1:0] row_word(input int r);
      logic [DIM*AW-1:0] w;
      for (int k = 0; k < DIM; k++) w[k*AW +: AW] = ma[r][k];
      return w;
   endfunction

   function automatic logic [DIM*AW-1:0] col_word(input int c);
      logic [DIM*AW-1:0] w;
      for (int k = 0; k < DIM; k++) w[k*AW +: AW] = mb[k][c];
      return w;
   endfunction

   function automatic logic [PW-1:0] ref_elem(input int i, input int j);
      int s = 0;
      for (int k = 0; k < DIM; k++) s += int'(ma[i][k]) * int'(mb[k][j]);
      return s[PW-1:0];
   endfunction

   // synchronous memory models: one-cycle read latency
   always @(posedge clk) begin
      if (a_ce) a_rd <= row_word(int'(a_addr));
      if (b_ce) b_rd <= col_word(int'(b_addr));
      if (c_ce && c_we) begin
         cmem[c_addr] <= c_wdata;
         wr_total     <= wr_total + 1;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic check_results(input string req);
      for (int i = 0; i < DIM; i++)
         for (int j = 0; j < DIM; j++)
            check(cmem[i*DIM+j] == ref_elem(i, j), req,
                  int'($signed(cmem[i*DIM+j])), int'($signed(ref_elem(i, j))));
   endtask

   // one run with per-cycle timing checks; extra start pulses optional (R7)
   task automatic run_timed(input string tag, input bit poke_busy);
      int rd_bad = 0, wr_bad = 0, idle_bad = 0, rdy_bad = 0;
      int done_cyc = -1, done_cnt = 0, w0;
      for (int i = 0; i < DIM*DIM; i++) cmem[i] = '1;
      w0 = wr_total;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      for (int cyc = 1; cyc <= 40; cyc++) begin
         if (poke_busy) start = (cyc == 10 || cyc == 27);
         if (a_ce != (cyc >= 1 && cyc <= 25) || b_ce != a_ce) rd_bad++;
         if (a_ce && (int'(a_addr) != (cyc-1)/DIM || int'(b_addr) != (cyc-1)%DIM)) rd_bad++;
         if (c_ce != (cyc >= 4 && cyc <= 28) || c_we != c_ce) wr_bad++;
         if (c_ce && int'(c_addr) != cyc - 4) wr_bad++;
         if (idle != (cyc >= 30)) idle_bad++;
         if (ready != done) rdy_bad++;
         if (done) begin
            done_cnt++;
            if (done_cyc < 0) done_cyc = cyc;
         end
         @(negedge clk);
      end
      start = 1'b0;
      check(rd_bad == 0,   {tag, " R2 read sequence"}, rd_bad, 0);
      check(wr_bad == 0,   {tag, " R4 write timing"}, wr_bad, 0);
      check(done_cyc == 29, {tag, " R6 done latency"}, done_cyc, 29);
      check(done_cnt == 1, {tag, poke_busy ? " R7 single done" : " R6 single done"}, done_cnt, 1);
      check(idle_bad == 0, {tag, " R6 idle window"}, idle_bad, 0);
      check(rdy_bad == 0,  {tag, " R6 ready with done"}, rdy_bad, 0);
      check(wr_total - w0 == DIM*DIM, {tag, " R4 write count"}, wr_total - w0, DIM*DIM);
   endtask

   task automatic t_reset;
      #5;
      check(idle == 1'b1, "R1 idle in reset", idle, 1);
      check(!done && !ready, "R1 done/ready in reset", int'(done) + int'(ready), 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(idle == 1'b1, "R1 idle after reset", idle, 1);
      check(!a_ce && !b_ce && !c_ce, "R1 no access before start",
            int'(a_ce) + int'(b_ce) + int'(c_ce), 0);
   endtask

   task automatic t_permute;   // anti-diagonal A times upper-triangular ones B
      for (int i = 0; i < DIM; i++)
         for (int j = 0; j < DIM; j++) begin
            ma[i][j] = (i + j == DIM - 1) ? 8'sd1 : 8'sd0;
            mb[i][j] = (j >= i) ? 8'sd1 : 8'sd0;
         end
      run_timed("permute", 1'b0);
      check_results("R4 permute product");
   endtask

   task automatic t_mixed;     // signed values in every lane, exercises packing (R3)
      int seed = 17;
      for (int i = 0; i < DIM; i++)
         for (int j = 0; j < DIM; j++) begin
            seed = (seed * 1103 + 12345) % 65521;
            ma[i][j] = AW'(seed);
            seed = (seed * 1103 + 12345) % 65521;
            mb[i][j] = AW'(seed >> 3);
         end
      run_timed("mixed", 1'b0);
      check_results("R3 mixed signed product");
   endtask

   task automatic t_wrap;      // R5: overflow wraps modulo 2^16
      for (int i = 0; i < DIM; i++)
         for (int j = 0; j < DIM; j++) begin
            ma[i][j] = -8'sd128;
            mb[i][j] = (j == 0) ? -8'sd128 : 8'sd127;
         end
      run_timed("wrap", 1'b0);
      check(cmem[0] == 16'd16384, "R5 wrap positive", int'($signed(cmem[0])), 16384);
      check($signed(cmem[1]) == -16'sd15744, "R5 wrap negative",
            int'($signed(cmem[1])), -15744);
      check_results("R5 wrap matrix");
   endtask

   task automatic t_busy_start;   // R7: starts during a run are ignored
      for (int i = 0; i < DIM; i++)
         for (int j = 0; j < DIM; j++) begin
            ma[i][j] = AW'(i - j);
            mb[i][j] = AW'(3 * i + j - 7);
         end
      run_timed("busy", 1'b1);
      check_results("R7 busy product");
   endtask

   task automatic t_back_to_back; // R8: start held through done
      int d1 = -1, d2 = -1, rd_first = -1, w0;
      w0 = wr_total;
      @(negedge clk) start = 1'b1;
      for (int cyc = 1; cyc <= 70; cyc++) begin
         @(negedge clk);
         if (done && d1 < 0) d1 = cyc;
         else if (done && d2 < 0) d2 = cyc;
         if (d1 > 0 && cyc == d1 + 1) begin
            start = 1'b0;
            rd_first = a_ce;
         end
      end
      check(d1 == 29, "R8 first done", d1, 29);
      check(rd_first == 1, "R8 restart read", rd_first, 1);
      check(d2 - d1 == 29, "R8 done spacing", d2 - d1, 29);
      check(wr_total - w0 == 2*DIM*DIM, "R8 write count", wr_total - w0, 2*DIM*DIM);
      check_results("R8 repeat product");
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      t_reset();
      t_permute();
      t_mixed();
      t_wrap();
      t_busy_start();
      t_back_to_back();
      repeat (5) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule